// File: doc/BRIEF.md
# Serial Host Control Port with Register Bank

This block lets a host microcontroller configure a codec-style device over three wires: an active-low frame enable, a shift clock and a single data line that the host drives for writes and the block drives for reads. Each access is a frame of twelve shift clocks. The first bit sets the direction, the next three select one of eight byte-wide registers, and the last eight carry the data. All bits go most significant first.

The register bank drives its contents as parallel control outputs to the rest of the chip. Register 7 cannot be written. It shows three status inputs, and only while the voice-detect enable in register 6 bit 7 is set. Register 5 holds nothing, and bits that have no function read as zero. The active-low reset pin also acts as a power-down request. It is ORed with the software power-down bit, register 0 bit 5, to form the chip power-down output. The shift clock, enable and data inputs are sampled by the block's system clock, which runs several times faster than the shift clock. Edges on the shift clock are found by comparing each sample with the one before it.

Top module: `ctl_port`

## Requirements
- R1: A frame is twelve rising shift-clock edges while `en_n` is low, carrying bits in this order: direction (0 = write, 1 = read), address bits 2 down to 0, then data bits 7 down to 0. A write updates the addressed register on the twelfth rising edge.
- R2: While `rst_n` is low, every register is held at its reset value at once, without waiting for a clock. All registers reset to 0x00 except register 2, which resets to 0x33.
- R3: The write-enable masks are: register 1 bits 3:0 only, register 6 bits 7:5 only, registers 0, 2, 3 and 4 all bits. Bits outside a mask always read as 0. `reg_flat[8*i +: 8]` shows register i.
- R4: In a read frame, the block drives data bits 7 down to 0 on `dio_out` with `dio_oe` high. Each bit changes after a falling shift-clock edge, starting with the edge that follows address bit 0. Each bit is valid at the next rising edge.
- R5: `dio_oe` is low whenever `en_n` is high, and it stays low throughout a write frame.
- R6: If `en_n` rises before the twelfth rising edge, no register changes, and the next frame starts again from its direction bit.
- R7: Writes to register 5 and to register 7 have no effect. Register 5 always reads 0x00.
- R8: Register 7 reads {`voice_det`, `noise_lvl[1:0]`, 5'b00000} when register 6 bit 7 is 1, and 0x00 otherwise.
- R9: `power_down` is high when `rst_n` is low or register 0 bit 5 is 1, and low otherwise.
- R10: Rising edges after the twelfth in the same frame change no register and shift nothing further.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset and power-down request |
| en_n | input | 1 | Active-low frame enable from the host |
| sck | input | 1 | Serial shift clock from the host |
| dio_in | input | 1 | Serial data from the host |
| dio_out | output | 1 | Serial read data to the host |
| dio_oe | output | 1 | Output enable for the data line driver |
| voice_det | input | 1 | Voice/silence detector status |
| noise_lvl | input | 2 | Transmit noise-level indicator |
| reg_flat | output | 64 | All eight registers, register i at bits 8*i+7 down to 8*i |
| power_down | output | 1 | Combined chip power-down |

## Verification
The bench cuts frames short after eight and after eleven clocks. A design that commits early, or that keeps its bit count across frames, would corrupt a register or shift the next frame's address. It writes to the read-only register and to the empty register, and it writes all ones to the partly used registers. This exposes a bank that stores unused bits or accepts writes it should refuse. It reads the status register with the gate open and closed, and with different status values. It runs a frame with extra clocks past the twelfth, which would change the stored value if the counter wrapped. It pulses reset in the middle of operation to confirm the 0x33 default and the OR that forms power-down.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
   typedef enum logic {
      DIR_WR = 1'b0,
      DIR_RD = 1'b1
   } dir_e;
endpackage

// File: rtl/ctlp_shift.sv
module ctlp_shift
   import ctlp_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_n,
   input  logic              sck,
   input  logic              sdi,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata
);
   localparam int FRAME = 1 + ADDR_W + DATA_W;
   localparam int HDR   = 1 + ADDR_W;
   localparam int CW    = $clog2(FRAME + 1);
   localparam int IW    = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   logic              sck_q;
   logic              rise, fall;
   logic [CW-1:0]     cnt;
   logic [DATA_W-2:0] sr;
   logic [HDR-1:0]    hdr_q;
   logic              drv_q, sdo_q;
   logic [IW-1:0]     bit_sel;
   dir_e              dir;

   assign rise    = sck & ~sck_q;
   assign fall    = ~sck & sck_q;
   assign dir     = dir_e'(hdr_q[ADDR_W]);
   assign addr    = hdr_q[ADDR_W-1:0];
   assign wdata   = {sr, sdi};
   assign bit_sel = IW'(CW'(FRAME - 1) - cnt);
   assign wr_stb  = rise & ~en_n & (cnt == CW'(FRAME - 1)) & (dir == DIR_WR);
   assign sdo     = sdo_q;
   assign sdo_oe  = drv_q & ~en_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cnt   <= '0;
         sr    <= '0;
         hdr_q <= '0;
         drv_q <= 1'b0;
         sdo_q <= 1'b0;
      end else begin
         sck_q <= sck;
         if (en_n) begin
            cnt   <= '0;
            hdr_q <= '0;
            drv_q <= 1'b0;
         end else begin
            if (rise && cnt < CW'(FRAME)) begin
               sr  <= {sr[DATA_W-3:0], sdi};
               cnt <= cnt + 1'b1;
               if (cnt == CW'(HDR - 1)) hdr_q <= {sr[HDR-2:0], sdi};
            end
            if (fall && dir == DIR_RD && cnt >= CW'(HDR) && cnt < CW'(FRAME)) begin
               sdo_q <= rd_data[bit_sel];
               drv_q <= 1'b1;
            end
         end
      end
   end

   p_drive_only_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> (dir == DIR_RD));
   p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(FRAME));
   p_write_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (cnt == CW'(FRAME)));
   p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en_n |=> (cnt == '0));
endmodule

// File: rtl/ctlp_regs.sv
module ctlp_regs #(
   parameter int                      NREG     = 8,
   parameter int                      ADDR_W   = 3,
   parameter int                      DATA_W   = 8,
   parameter int                      STAT_W   = 3,
   parameter logic [NREG*DATA_W-1:0]  RST_VEC  = '0,
   parameter logic [NREG*DATA_W-1:0]  WR_MASK  = '1,
   parameter int                      RO_IDX   = 7,
   parameter int                      GATE_IDX = 6,
   parameter int                      GATE_BIT = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_stb,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [STAT_W-1:0]        status,
   output logic [DATA_W-1:0]        rd_data,
   output logic [NREG*DATA_W-1:0]   regs_flat
);
   logic [DATA_W-1:0] view [NREG];
   logic              gate_on;

   assign gate_on = view[GATE_IDX][GATE_BIT];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [DATA_W-1:0] MSK = WR_MASK[g*DATA_W +: DATA_W];
      localparam logic [DATA_W-1:0] RST = RST_VEC[g*DATA_W +: DATA_W] & MSK;
      if (g == RO_IDX) begin : g_ro
         assign view[g] = gate_on ? {status, {(DATA_W-STAT_W){1'b0}}} : '0;
         p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !gate_on |-> (regs_flat[g*DATA_W +: DATA_W] == '0));
      end else begin : g_rw
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= RST;
            else if (wr_stb && addr == ADDR_W'(g))   q <= wdata & MSK;
         end
         assign view[g] = q;
         if (MSK == '0) begin : g_null
            p_null_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
               regs_flat[g*DATA_W +: DATA_W] == '0);
         end
      end
      assign regs_flat[g*DATA_W +: DATA_W] = view[g];
   end

   assign rd_data = view[addr];
endmodule

// File: rtl/ctl_port.sv
module ctl_port #(
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 8,
   parameter logic [(2**ADDR_W)*DATA_W-1:0] RST_VEC = 64'h0000_0000_0033_0000,
   parameter logic [(2**ADDR_W)*DATA_W-1:0] WR_MASK = 64'h00E0_00FF_FFFF_0FFF,
   parameter int RO_IDX   = 7,
   parameter int GATE_IDX = 6,
   parameter int GATE_BIT = 7,
   parameter int PD_IDX   = 0,
   parameter int PD_BIT   = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            en_n,
   input  logic                            sck,
   input  logic                            dio_in,
   output logic                            dio_out,
   output logic                            dio_oe,
   input  logic                            voice_det,
   input  logic [1:0]                      noise_lvl,
   output logic [(2**ADDR_W)*DATA_W-1:0]   reg_flat,
   output logic                            power_down
);
   localparam int NREG   = 2**ADDR_W;
   localparam int STAT_W = 3;

   if (DATA_W < ADDR_W + 2) begin : g_chk_w
      $error("DATA_W must be at least ADDR_W+2");
   end
   if (RO_IDX >= NREG || GATE_IDX >= NREG || PD_IDX >= NREG) begin : g_chk_idx
      $error("register index out of range");
   end
   if (GATE_BIT >= DATA_W || PD_BIT >= DATA_W || STAT_W > DATA_W) begin : g_chk_bit
      $error("bit position out of range");
   end

   logic              wr_stb;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wdata, rd_data;

   ctlp_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .en_n(en_n), .sck(sck), .sdi(dio_in),
      .rd_data(rd_data), .sdo(dio_out), .sdo_oe(dio_oe),
      .wr_stb(wr_stb), .addr(addr), .wdata(wdata)
   );

   ctlp_regs #(
      .NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W),
      .RST_VEC(RST_VEC), .WR_MASK(WR_MASK), .RO_IDX(RO_IDX),
      .GATE_IDX(GATE_IDX), .GATE_BIT(GATE_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
      .status({voice_det, noise_lvl}), .rd_data(rd_data), .regs_flat(reg_flat)
   );

   assign power_down = ~rst_n | reg_flat[PD_IDX*DATA_W + PD_BIT];

   p_sw_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_flat[PD_IDX*DATA_W + PD_BIT]) |-> power_down);
   p_no_oe_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en_n |-> !dio_oe);
endmodule

// File: tb/ctl_port_tb.sv
module ctl_port_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_n = 1'b1;
   logic        sck = 1'b1;
   logic        dio_in = 1'b0;
   logic        voice_det = 1'b0;
   logic [1:0]  noise_lvl = 2'b00;
   logic        dio_out, dio_oe, power_down;
   logic [63:0] reg_flat;

   int vectors = 0;
   int miscompares = 0;
   int cycles = 0;
   bit in_write = 1'b0;
   bit done = 1'b0;

   logic [7:0] model [8];
   localparam logic [7:0] MASK [8] =
      '{8'hFF, 8'h0F, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hE0, 8'h00};

   always #(CLK_PERIOD/2) clk = ~clk;

   ctl_port u_dut (
      .clk(clk), .rst_n(rst_n), .en_n(en_n), .sck(sck), .dio_in(dio_in),
      .dio_out(dio_out), .dio_oe(dio_oe), .voice_det(voice_det),
      .noise_lvl(noise_lvl), .reg_flat(reg_flat), .power_down(power_down)
   );

   function automatic logic [7:0] exp_reg(input int i);
      if (i == 7) return model[6][7] ? {voice_det, noise_lvl, 5'b0} : 8'h00;
      return model[i];
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 8; i++) model[i] = 8'h00;
      model[2] = 8'h33;
   endtask

   // per-cycle comparison against the reference model
   always @(posedge clk) begin
      #1;
      if (!done) begin
         for (int i = 0; i < 8; i++)
            check(reg_flat[8*i +: 8] === exp_reg(i), $sformatf("R3 reg%0d", i),
                  64'(reg_flat[8*i +: 8]), 64'(exp_reg(i)));
         check(power_down === (!rst_n || model[0][5]), "R9 power_down",
               64'(power_down), 64'(!rst_n || model[0][5]));
         if (en_n || in_write)
            check(dio_oe === 1'b0, "R5 dio_oe idle/write", 64'(dio_oe), 64'(0));
      end
   end

   // nclk rising edges; write committed to model on the twelfth
   task automatic frame(input logic rd, input logic [2:0] a, input logic [7:0] d,
                        input int nclk, output logic [7:0] got);
      logic [11:0] word;
      logic [7:0]  expv;
      word = {rd, a, d};
      expv = exp_reg(int'(a));
      got = 8'h00;
      in_write = !rd;
      en_n = 1'b0;
      @(negedge clk);
      for (int i = 0; i < nclk; i++) begin
         sck = 1'b0;
         dio_in = (i < 12) ? word[11-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         if (rd && i >= 4 && i < 12) begin
            got[11-i] = dio_out;
            check(dio_oe === 1'b1, "R4 read drive enable", 64'(dio_oe), 64'(1));
            check(dio_out === expv[11-i], $sformatf("R4 read bit %0d", 11-i),
                  64'(dio_out), 64'(expv[11-i]));
         end
         sck = 1'b1;
         @(posedge clk);
         if (i == 11 && !rd) model[a] = d & MASK[a];
         repeat (HALF) @(negedge clk);
      end
      en_n = 1'b1;
      in_write = 1'b0;
      @(negedge clk);
      check(dio_oe === 1'b0, "R5 release after frame", 64'(dio_oe), 64'(0));
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      logic [7:0] g;
      frame(1'b0, a, d, 12, g);
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
      logic [7:0] g;
      frame(1'b1, a, 8'h00, 12, g);
      check(g === e, tag, 64'(g), 64'(e));
   endtask

   initial begin
      logic [7:0] g;
      model_reset();
      repeat (3) @(negedge clk);
      check(reg_flat === 64'h0000_0000_0033_0000, "R2 reset values", reg_flat,
            64'h0000_0000_0033_0000);
      check(power_down === 1'b1, "R9 pin reset powers down", 64'(power_down), 64'(1));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      rd_chk(3'd2, 8'h33, "R2 reg2 default readback");

      // R1 writes and readback
      wr(3'd0, 8'hA5);
      check(power_down === 1'b1, "R9 software power-down", 64'(power_down), 64'(1));
      rd_chk(3'd0, 8'hA5, "R1 reg0 readback");
      wr(3'd3, 8'h5A);
      wr(3'd4, 8'h81);
      wr(3'd2, 8'hC3);
      rd_chk(3'd3, 8'h5A, "R1 reg3 readback");
      rd_chk(3'd2, 8'hC3, "R1 reg2 readback");
      wr(3'd0, 8'h00);
      check(power_down === 1'b0, "R9 power-up", 64'(power_down), 64'(0));

      // R3 masked bits
      wr(3'd1, 8'hFF);
      rd_chk(3'd1, 8'h0F, "R3 reg1 mask");
      wr(3'd6, 8'h1F);
      rd_chk(3'd6, 8'h00, "R3 reg6 low bits unused");

      // R7 ignored writes, R8 gate closed
      voice_det = 1'b1; noise_lvl = 2'b10;
      wr(3'd5, 8'hFF);
      rd_chk(3'd5, 8'h00, "R7 reg5 write ignored");
      wr(3'd7, 8'hFF);
      rd_chk(3'd7, 8'h00, "R8 status gated off / R7 reg7 write ignored");

      // R8 gate open
      wr(3'd6, 8'hFF);
      rd_chk(3'd6, 8'hE0, "R3 reg6 mask");
      rd_chk(3'd7, 8'hC0, "R8 status vd=1 nl=2");
      voice_det = 1'b0; noise_lvl = 2'b11;
      rd_chk(3'd7, 8'h60, "R8 status vd=0 nl=3");

      // R6 aborted frames
      frame(1'b0, 3'd3, 8'h00, 8, g);
      check(reg_flat[8*3 +: 8] === 8'h5A, "R6 abort after 8", 64'(reg_flat[8*3 +: 8]), 64'h5A);
      frame(1'b0, 3'd3, 8'h00, 11, g);
      check(reg_flat[8*3 +: 8] === 8'h5A, "R6 abort after 11", 64'(reg_flat[8*3 +: 8]), 64'h5A);
      rd_chk(3'd4, 8'h81, "R6 next frame aligned");

      // R10 extra clocks
      frame(1'b0, 3'd4, 8'h3C, 15, g);
      check(reg_flat[8*4 +: 8] === 8'h3C, "R10 extra clocks", 64'(reg_flat[8*4 +: 8]), 64'h3C);

      // R2 mid-run reset
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      check(reg_flat === 64'h0000_0000_0033_0000, "R2 mid-run reset", reg_flat,
            64'h0000_0000_0033_0000);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      rd_chk(3'd7, 8'h00, "R8 gate cleared by reset");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule